// File: doc/BRIEF.md
# Copy-Request Descriptor Sequencer

This block turns one memory-copy request into the run of 128-bit descriptors a copy engine consumes from a circular ring. A request carries a source address, a destination address, a byte length, a fence flag and an interrupt flag. An alternative immediate-write request instead carries one 64-bit value and its target address. The block owns the producer index of the ring. It reads the consumer index from outside and works out how many ring slots are free. Only if the whole sequence fits does it write the descriptors, one per clock, into consecutive slots. It then reports the new producer index with a done pulse and a pass/fail code.

A copy longer than the largest chunk the engine accepts is cut into full chunks followed by a shorter tail. Each chunk's source and destination addresses move forward by the bytes already covered. The size select picks the largest chunk: either 512 KiB, or 1 MiB less one alignment unit. A fence adds one status descriptor that writes zero to a fixed status location. The engine raises an interrupt only reliably when its status write comes doubled, so an interrupt request adds two status descriptors, and only the second one carries the interrupt bit. Three slots are always held back for these trailing status descriptors when space is checked.

Lengths are assumed to be multiples of the alignment unit (64 bytes by default). Ringing the engine's doorbell and retiring finished descriptors are left to neighbouring logic.

Top module: `desc_seq_gen`

## Requirements
- R1: After reset `prod_idx` is 0, `wr_en` and `done` are low and `req_ready` is high.
- R2: A copy of L bytes is written as ceil(L/C) copy descriptors, where C is the chunk size. Every chunk but the last is C bytes long, and each chunk's source and destination are the request's addresses plus the bytes before it. Writes land one per clock at consecutive ring indices, starting at `prod_idx` and wrapping after DEPTH-1.
- R3: `size_sel`=0 gives C = 524288 bytes and `size_sel`=1 gives C = 1048576-64 bytes.
- R4: A copy needs ceil(L/C)+3 free slots and an immediate write needs 4. When the need exceeds the free count, `done` pulses with `done_ok`=0, no descriptor is written and `prod_idx` does not change.
- R5: With producer index H and consumer index T, the free count is T+DEPTH-H-1 when H>=T and T-H-1 otherwise, so one slot always stays empty.
- R6: A fence appends one status descriptor after the payload descriptors. It carries data 0, address `stat_addr` and interrupt bit 0.
- R7: An interrupt appends two status descriptors after the fence, if there is one. Both carry data 0 and address `stat_addr`; the first has interrupt bit 0 and the second has interrupt bit 1.
- R8: A copy with length 0 and no flags fails at once with no writes. A copy with length 0 and at least one flag writes only its status descriptors.
- R9: An immediate request (`req_imm`=1) writes one status descriptor with data `req_value`, address `req_dst` and interrupt bit 0, followed by the fence and interrupt descriptors.
- R10: `req_ready` is low from the cycle after acceptance until `done`. On success `done_ok`=1 and `prod_idx` has advanced by the number of descriptors written, modulo DEPTH.
- R11: Descriptor fields are: bits [127:126] are the kind (01 copy, 10 status), bit 125 is the interrupt request, and bits [103:64] are the destination address. In a copy descriptor, bits [63:44] hold the length in 64-byte units and bits [39:0] the source address. In a status descriptor, bits [63:0] hold the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_imm | input | 1 | 1: immediate-write request, 0: copy request |
| req_src | input | 40 | Copy source address |
| req_dst | input | 40 | Copy destination or immediate target address |
| req_len | input | 32 | Copy length in bytes |
| req_value | input | 64 | Immediate data value |
| req_fence | input | 1 | Append a fence status descriptor |
| req_irq | input | 1 | Append the doubled interrupt status descriptors |
| size_sel | input | 1 | Largest-chunk select |
| stat_addr | input | 40 | Address the fence and interrupt descriptors write to |
| cons_idx | input | 4 | Consumer (last retired) ring index |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | 4 | Ring slot being written |
| wr_desc | output | 128 | Descriptor word |
| done | output | 1 | One-cycle end-of-request pulse |
| done_ok | output | 1 | With done: 1 sequence written, 0 rejected |
| prod_idx | output | 4 | Producer index (next slot to write) |

## Verification
The chunk counter, the remaining-length register and the phase register each drive what appears on `wr_desc` and `wr_idx`. A fault in any of them shows in the same request as a wrong descriptor count, a chunk length or address off by one step, or a missing or reordered status word. A wrong free-count or need comparison shows as a `done_ok` that disagrees with the arithmetic, and the clearest sign is a sweep of the consumer index around a fixed producer index. A slip in producer-index stepping shows at the next `done` as a `prod_idx` that no longer matches the descriptors counted.

// File: rtl/dsg_pkg.sv
// Shared types and constants for the descriptor sequencer.
// Assumes a 128-bit descriptor with the kind code in its top two bits.
package dsg_pkg;
    localparam int DESC_W = 128;
    localparam logic [1:0] KIND_COPY = 2'b01;
    localparam logic [1:0] KIND_STAT = 2'b10;

    typedef enum logic [1:0] {S_IDLE, S_COUNT, S_EMIT} state_e;

    typedef enum logic [2:0] {
        PH_CHUNK, PH_IMM, PH_FENCE, PH_IRQ0, PH_IRQ1, PH_END
    } phase_e;

    // First status phase after the payload, chosen from the flags.
    function automatic phase_e after_payload(input logic fence, input logic irq);
        if (fence)    return PH_FENCE;
        else if (irq) return PH_IRQ0;
        else          return PH_END;
    endfunction
endpackage

// File: rtl/dsg_ring_space.sv
// Free-slot count of a circular ring from the producer and consumer indices.
// Assumes one slot is always left empty, so the maximum is DEPTH-1.
module dsg_ring_space #(
    parameter int DEPTH = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int FREE_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]  head,
    input  logic [IDX_W-1:0]  tail,
    output logic [FREE_W-1:0] free_cnt
);
    localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

    generate
        if (POW2) begin : g_pow2
            logic [IDX_W-1:0] diff;
            // Modular difference is exact when the depth is a power of two.
            assign diff     = tail - head - IDX_W'(1);
            assign free_cnt = {1'b0, diff};
        end else begin : g_any
            // Two-branch form for a ring of arbitrary depth.
            always_comb begin
                if (head >= tail)
                    free_cnt = FREE_W'(tail) + FREE_W'(DEPTH) - FREE_W'(head) - FREE_W'(1);
                else
                    free_cnt = FREE_W'(tail) - FREE_W'(head) - FREE_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/dsg_chunk_step.sv
// One chunking step: the next chunk's length and the advanced addresses.
// Assumes ALIGN_BYTES is a power of two and lengths are multiples of it.
module dsg_chunk_step #(
    parameter int LEN_W       = 32,
    parameter int ADDR_W      = 40,
    parameter int ALIGN_BYTES = 64,
    parameter int BASE_CHUNK  = 524288,
    parameter int UNIT_W      = 20
) (
    input  logic              size_sel,
    input  logic [LEN_W-1:0]  rem_len,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    output logic [UNIT_W-1:0] step_units,
    output logic [LEN_W-1:0]  rem_next,
    output logic [ADDR_W-1:0] src_next,
    output logic [ADDR_W-1:0] dst_next
);
    localparam int ALIGN_SH = $clog2(ALIGN_BYTES);
    localparam logic [LEN_W-1:0] CHUNK_LO = LEN_W'(BASE_CHUNK);
    localparam logic [LEN_W-1:0] CHUNK_HI = LEN_W'(2 * BASE_CHUNK - ALIGN_BYTES);

    logic [LEN_W-1:0] chunk;
    logic [LEN_W-1:0] step;

    // Pick the chunk limit and clip the remaining length to it.
    always_comb begin
        chunk      = size_sel ? CHUNK_HI : CHUNK_LO;
        step       = (rem_len < chunk) ? rem_len : chunk;
        step_units = step[ALIGN_SH +: UNIT_W];
        rem_next   = rem_len - step;
        src_next   = src + ADDR_W'(step);
        dst_next   = dst + ADDR_W'(step);
    end
endmodule

// File: rtl/dsg_desc_pack.sv
// Assembles one 128-bit descriptor from the fields of the current phase.
// Assumes ADDR_W + UNIT_W < 64 so the copy low word has a spare gap.
module dsg_desc_pack
    import dsg_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int UNIT_W = 20
) (
    input  logic              is_copy,
    input  logic              irq,
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] src,
    input  logic [UNIT_W-1:0] units,
    input  logic [63:0]       data,
    output logic [DESC_W-1:0] desc
);
    logic [63:0] lo_word;
    logic [63:0] hi_word;

    // Copy descriptors carry length and source, status ones carry data.
    always_comb begin
        lo_word = is_copy ? {units, {(64 - UNIT_W - ADDR_W){1'b0}}, src} : data;
        hi_word = {(is_copy ? KIND_COPY : KIND_STAT), irq, {(61 - ADDR_W){1'b0}}, dst};
        desc    = {hi_word, lo_word};
    end
endmodule

// File: rtl/desc_seq_gen.sv
// Descriptor sequencer top. It accepts a copy or immediate request and
// counts the chunks it needs (one per cycle, stopping early once space
// runs out). It checks the free ring space and then writes the whole
// sequence one descriptor per clock.
// Assumes the consumer index only moves so as to add free space while busy.
module desc_seq_gen
    import dsg_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 40,
    parameter int LEN_W       = 32,
    parameter int ALIGN_BYTES = 64,
    parameter int BASE_CHUNK  = 524288,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_imm,
    input  logic [ADDR_W-1:0]    req_src,
    input  logic [ADDR_W-1:0]    req_dst,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [63:0]          req_value,
    input  logic                 req_fence,
    input  logic                 req_irq,
    input  logic                 size_sel,
    input  logic [ADDR_W-1:0]    stat_addr,
    input  logic [IDX_W-1:0]     cons_idx,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [DESC_W-1:0]    wr_desc,
    output logic                 done,
    output logic                 done_ok,
    output logic [IDX_W-1:0]     prod_idx
);
    localparam int FREE_W = IDX_W + 1;
    localparam int CNT_W  = $clog2(DEPTH + 4) + 1;
    localparam int UNIT_W = 20;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] RESERVE  = CNT_W'(3);
    localparam logic [CNT_W-1:0] IMM_NEED = CNT_W'(4);
    localparam logic [UNIT_W-1:0] MAX_UNITS = UNIT_W'((2 * BASE_CHUNK - ALIGN_BYTES) / ALIGN_BYTES);

    // Advance a ring index with wrap-around.
    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + IDX_W'(1);
    endfunction

    state_e             state;
    phase_e             phase;
    phase_e             phase_nxt;
    phase_e             phase_entry;
    logic               imm_l, fence_l, irq_l, sel_l;
    logic [LEN_W-1:0]   len_l;
    logic [LEN_W-1:0]   rem_len;
    logic [ADDR_W-1:0]  cur_src, cur_dst, stat_l;
    logic [63:0]        value_l;
    logic [CNT_W-1:0]   cnt;
    logic [FREE_W-1:0]  free_cnt;
    logic [CNT_W-1:0]   free_ext;
    logic [UNIT_W-1:0]  step_units;
    logic [LEN_W-1:0]   rem_next;
    logic [ADDR_W-1:0]  src_next, dst_next;
    logic [DESC_W-1:0]  desc_cur;
    logic [ADDR_W-1:0]  desc_dst;
    logic [63:0]        desc_data;
    logic               req_empty;

    dsg_ring_space #(.DEPTH(DEPTH)) u_space (
        .head     (prod_idx),
        .tail     (cons_idx),
        .free_cnt (free_cnt)
    );

    dsg_chunk_step #(
        .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES),
        .BASE_CHUNK(BASE_CHUNK), .UNIT_W(UNIT_W)
    ) u_step (
        .size_sel   (sel_l),
        .rem_len    (rem_len),
        .src        (cur_src),
        .dst        (cur_dst),
        .step_units (step_units),
        .rem_next   (rem_next),
        .src_next   (src_next),
        .dst_next   (dst_next)
    );

    dsg_desc_pack #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_pack (
        .is_copy (phase == PH_CHUNK),
        .irq     (phase == PH_IRQ1),
        .dst     (desc_dst),
        .src     (cur_src),
        .units   (step_units),
        .data    (desc_data),
        .desc    (desc_cur)
    );

    assign req_ready = (state == S_IDLE);
    assign free_ext  = CNT_W'(free_cnt);
    assign req_empty = !req_imm && (req_len == '0) && !req_fence && !req_irq;

    // Address and data of the descriptor for the current phase.
    always_comb begin
        desc_dst  = stat_l;
        desc_data = '0;
        if (phase == PH_CHUNK || phase == PH_IMM) desc_dst = cur_dst;
        if (phase == PH_IMM) desc_data = value_l;
    end

    // Phase order: payload, then fence, then the interrupt pair.
    always_comb begin
        phase_entry = imm_l ? PH_IMM :
                      (len_l != '0) ? PH_CHUNK : after_payload(fence_l, irq_l);
        case (phase)
            PH_CHUNK: phase_nxt = (rem_next != '0) ? PH_CHUNK : after_payload(fence_l, irq_l);
            PH_IMM:   phase_nxt = after_payload(fence_l, irq_l);
            PH_FENCE: phase_nxt = irq_l ? PH_IRQ0 : PH_END;
            PH_IRQ0:  phase_nxt = PH_IRQ1;
            default:  phase_nxt = PH_END;
        endcase
    end

    // Request control: accept, count and check space, then emit descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            phase    <= PH_END;
            imm_l    <= 1'b0;
            fence_l  <= 1'b0;
            irq_l    <= 1'b0;
            sel_l    <= 1'b0;
            len_l    <= '0;
            rem_len  <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            stat_l   <= '0;
            value_l  <= '0;
            cnt      <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_desc  <= '0;
            done     <= 1'b0;
            done_ok  <= 1'b0;
            prod_idx <= '0;
        end else begin
            wr_en   <= 1'b0;
            done    <= 1'b0;
            done_ok <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        imm_l   <= req_imm;
                        fence_l <= req_fence;
                        irq_l   <= req_irq;
                        sel_l   <= size_sel;
                        len_l   <= req_len;
                        rem_len <= req_imm ? '0 : req_len;
                        cur_src <= req_src;
                        cur_dst <= req_dst;
                        stat_l  <= stat_addr;
                        value_l <= req_value;
                        cnt     <= '0;
                        if (req_empty) begin
                            done <= 1'b1;
                        end else begin
                            state <= S_COUNT;
                        end
                    end
                end
                S_COUNT: begin
                    if (imm_l || rem_len == '0) begin
                        if ((imm_l ? IMM_NEED : cnt + RESERVE) > free_ext) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            rem_len <= len_l;
                            phase   <= phase_entry;
                            state   <= S_EMIT;
                        end
                    end else if (cnt + CNT_W'(1) + RESERVE > free_ext) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        cnt     <= cnt + CNT_W'(1);
                        rem_len <= rem_next;
                    end
                end
                S_EMIT: begin
                    wr_en    <= 1'b1;
                    wr_idx   <= prod_idx;
                    wr_desc  <= desc_cur;
                    prod_idx <= idx_next(prod_idx);
                    if (phase == PH_CHUNK) begin
                        rem_len <= rem_next;
                        cur_src <= src_next;
                        cur_dst <= dst_next;
                    end
                    phase <= phase_nxt;
                    if (phase_nxt == PH_END) begin
                        done    <= 1'b1;
                        done_ok <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Back-to-back writes occupy consecutive ring slots.
    p_consec_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_idx == idx_next($past(wr_idx)));

    // Copy chunks are never empty and never exceed the larger chunk limit.
    p_chunk_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_desc[127:126] == KIND_COPY |->
            wr_desc[63:44] != '0 && wr_desc[63:44] <= MAX_UNITS);

    // A rejected request writes nothing and leaves the producer index alone.
    p_fail_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_ok |-> !wr_en && prod_idx == $past(prod_idx));

    // The interrupting status word always follows a quiet status word.
    p_irq_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_desc[125] |->
            $past(wr_en) && $past(wr_desc[127:126]) == KIND_STAT && !$past(wr_desc[125]));

    // The block is ready again in the cycle it reports done.
    p_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/test_desc_seq_gen.sv
// Sweeps chunk sizes, lengths, flag mixes, immediate writes and consumer
// positions. Every expected descriptor is built arithmetically here.
module test_desc_seq_gen;
    localparam int DEPTH = 16;
    localparam int AW    = 40;
    localparam longint C0 = 524288;
    localparam longint C1 = 1048576 - 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_imm = 1'b0;
    logic [AW-1:0] req_src = '0;
    logic [AW-1:0] req_dst = '0;
    logic [31:0]   req_len = '0;
    logic [63:0]   req_value = '0;
    logic          req_fence = 1'b0;
    logic          req_irq = 1'b0;
    logic          size_sel = 1'b0;
    logic [AW-1:0] stat_addr = 40'hAB_CDEF_0040;
    logic [3:0]    cons_idx = '0;
    logic          wr_en;
    logic [3:0]    wr_idx;
    logic [127:0]  wr_desc;
    logic          done;
    logic          done_ok;
    logic [3:0]    prod_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int head_m = 0;

    logic [127:0] exp_d [0:31];
    logic [127:0] got_d [0:31];
    logic [3:0]   got_i [0:31];

    always #5 clk = ~clk;

    desc_seq_gen i_desc_seq_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_imm(req_imm), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .req_value(req_value), .req_fence(req_fence), .req_irq(req_irq),
        .size_sel(size_sel), .stat_addr(stat_addr), .cons_idx(cons_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_desc(wr_desc), .done(done),
        .done_ok(done_ok), .prod_idx(prod_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] got,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Copy descriptor per R11.
    function automatic logic [127:0] mk_copy(input logic [AW-1:0] s, input logic [AW-1:0] d,
                                             input longint bytes);
        logic [19:0] units;
        units = 20'(bytes / 64);
        return {2'b01, 1'b0, 21'b0, d, units, 4'b0, s};
    endfunction

    // Status descriptor per R11.
    function automatic logic [127:0] mk_stat(input logic [AW-1:0] a, input logic [63:0] v,
                                             input bit irq);
        return {2'b10, irq, 21'b0, a, v};
    endfunction

    task automatic do_req(input bit imm, input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input longint len, input logic [63:0] val, input bit fence,
                          input bit irq, input bit sel, input string tag);
        longint c, rem, step;
        int free, need, nch, en, gn, cyc;
        bit rej, exp_ok, fin, first, got_ok;
        logic [AW-1:0] s, d;
        c    = sel ? C1 : C0;
        free = (head_m >= int'(cons_idx)) ? int'(cons_idx) + DEPTH - head_m - 1
                                          : int'(cons_idx) - head_m - 1;
        rej  = !imm && len == 0 && !fence && !irq;
        nch  = int'(len / c) + ((len % c) != 0 ? 1 : 0);
        need = imm ? 4 : nch + 3;
        exp_ok = !rej && need <= free;
        en = 0;
        if (imm) begin
            exp_d[en] = mk_stat(dst, val, 1'b0); en++;
        end else begin
            rem = len; s = src; d = dst;
            while (rem > 0) begin
                step = (rem < c) ? rem : c;
                exp_d[en] = mk_copy(s, d, step); en++;
                s = s + AW'(step); d = d + AW'(step); rem = rem - step;
            end
        end
        if (fence) begin exp_d[en] = mk_stat(stat_addr, 64'd0, 1'b0); en++; end
        if (irq) begin
            exp_d[en] = mk_stat(stat_addr, 64'd0, 1'b0); en++;
            exp_d[en] = mk_stat(stat_addr, 64'd0, 1'b1); en++;
        end
        if (!exp_ok) en = 0;

        @(negedge clk);
        req_imm = imm; req_src = src; req_dst = dst; req_len = 32'(len);
        req_value = val; req_fence = fence; req_irq = irq; size_sel = sel;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        gn = 0; fin = 0; cyc = 0; first = 1; got_ok = 0;
        while (!fin && cyc < 300) begin
            if (first && !rej)
                check(req_ready == 1'b0, {tag, " R10 busy"}, 128'(req_ready), 128'(0));
            first = 0;
            if (wr_en) begin
                if (gn < 32) begin got_d[gn] = wr_desc; got_i[gn] = wr_idx; end
                gn++;
            end
            if (done) begin
                fin = 1; got_ok = done_ok;
            end else begin
                @(negedge clk); cyc++;
            end
        end
        check(fin, {tag, " watchdog"}, 128'(fin), 128'(1));
        check(got_ok == exp_ok, {tag, " R4 R5 R8 status"}, 128'(got_ok), 128'(exp_ok));
        check(gn == en, {tag, " R2 R8 count"}, 128'(gn), 128'(en));
        for (int k = 0; k < en && k < gn; k++) begin
            check(got_d[k] == exp_d[k], {tag, " R2 R3 R6 R7 R9 R11 desc"}, got_d[k], exp_d[k]);
            check(got_i[k] == 4'((head_m + k) % DEPTH), {tag, " R2 index"},
                  128'(got_i[k]), 128'((head_m + k) % DEPTH));
        end
        head_m = (head_m + en) % DEPTH;
        check(prod_idx == 4'(head_m), {tag, " R10 prod_idx"}, 128'(prod_idx), 128'(head_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint lens [0:11];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(prod_idx == 0 && !wr_en && !done && req_ready, "R1 reset",
              {prod_idx, wr_en, done, req_ready}, {4'd0, 3'b001});

        // Length and flag sweep with the ring drained (free = DEPTH-1).
        for (int sel = 0; sel < 2; sel++) begin
            longint c;
            c = sel ? C1 : C0;
            lens[0] = 0;       lens[1] = 64;        lens[2] = c - 64;   lens[3] = c;
            lens[4] = c + 64;  lens[5] = 2 * c;     lens[6] = 3 * c - 128;
            lens[7] = 5 * c + 64; lens[8] = 11 * c; lens[9] = 12 * c;
            lens[10] = 12 * c + 64; lens[11] = 13 * c;
            for (int li = 0; li < 12; li++)
                for (int fl = 0; fl < 4; fl++) begin
                    cons_idx = 4'(head_m);
                    do_req(1'b0, 40'h10_0000_0000 + AW'(li * 4096), 40'h20_0000_0000 + AW'(fl * 64),
                           lens[li], 64'd0, fl[0], fl[1], sel[0],
                           $sformatf("copy sel=%0d len=%0d fl=%0d", sel, lens[li], fl));
                end
        end

        // R9 immediate writes under every flag mix.
        for (int fl = 0; fl < 4; fl++) begin
            cons_idx = 4'(head_m);
            do_req(1'b1, 40'h0, 40'h33_0000_0100 + AW'(fl), 0, 64'hDEAD_BEEF_0000_0000 + 64'(fl),
                   fl[0], fl[1], 1'b0, $sformatf("R9 imm fl=%0d", fl));
        end

        // R5 consumer-index sweep: immediate (needs 4) and two-chunk copy (needs 5).
        for (int t = 0; t < DEPTH; t++) begin
            cons_idx = 4'(t);
            do_req(1'b1, 40'h0, 40'h44_0000_0000, 0, 64'(t), 1'b0, 1'b0, 1'b0,
                   $sformatf("R5 imm tail=%0d head=%0d", t, head_m));
            do_req(1'b0, 40'h55_0000_0000, 40'h66_0000_0000, 2 * C0, 64'd0, 1'b0, 1'b0, 1'b0,
                   $sformatf("R5 copy tail=%0d head=%0d", t, head_m));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule